// File: doc/BRIEF.md
# Tiny 16-bit Register Processor Core

This block is a small multi-cycle processor. It fetches 16-bit instruction words from a private program store, decodes a 4-bit operation code together with register or immediate fields, and executes one instruction at a time. The processor state is an 8-bit program counter and five 16-bit general-purpose registers. The core has no data memory. Character traffic uses two system-call services that drive simple valid/ready byte ports.

The program store is loaded through a write port while the core is held in reset. After reset is released, the core starts executing at address 0. It runs until it executes a halt instruction or its program counter reaches the unused top address 255. It then raises a sticky halted flag and does nothing more until the next reset. A typical program is a loop: a zero test at the loop head jumps past the body, and an unconditional jump at the loop tail returns to the head.

Instruction word layout: bits 15:12 hold the opcode, bits 11:8 the destination register `d`, bits 7:4 source register `a`, and bits 3:0 source register `b`. The immediate `k` occupies bits 7:0 and overlaps both source fields.

Top module: `tiny16_core`

## Requirements
- R1: Opcode 1 writes `k`, zero-extended to 16 bits, into register `d`.
- R2: Opcode 2 writes `a + b` and opcode 3 writes `a - b` into `d`. Both results wrap modulo 2^16.
- R3: Opcode 4 writes `d + k` and opcode 5 writes `d - k` back into `d`. Both results wrap modulo 2^16.
- R4: Opcode 6 loads `k` into the program counter. Opcode 7 loads `k` when register `d` equals zero and otherwise steps to the next address.
- R5: Register index 0 and indices 6 to 15 always read as zero, and writes to them are discarded. Registers 1 to 5 hold their values.
- R6: Opcode 8 with `k` = 1 raises `out_valid` with the low byte of register `d` on `out_data`. Both stay unchanged until `out_ready` is high at a clock edge, and then execution continues.
- R7: Opcode 8 with `k` = 2 raises `in_ready` until `in_valid` is high at a clock edge. At that edge `in_data` is written into `d`, zero-extended. `out_valid` and `in_ready` are never high together.
- R8: Opcode 15, or the program counter reaching 255, sets `halted`. `halted` then stays high until reset, and no further instruction or handshake takes place.
- R9: `prog_we` writes into the program store only while `rst_n` is low. A write with `rst_n` high leaves the stored program unchanged.
- R10: Every instruction other than the two byte services takes exactly two clock cycles. Opcodes 9 to 14, and opcode 8 with any other `k`, behave as no-operations.
- R11: In reset, `halted`, `out_valid` and `in_ready` are low. Every reset clears all registers to zero and restarts execution at address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset; also opens the program store for writing |
| prog_we | input | 1 | Program store write strobe (effective only while in reset) |
| prog_addr | input | 8 | Program store write address (0 to 254) |
| prog_data | input | 16 | Instruction word to store |
| out_data | output | 8 | Outgoing character |
| out_valid | output | 1 | Outgoing character is available |
| out_ready | input | 1 | Receiver accepts the outgoing character |
| in_data | input | 8 | Incoming character |
| in_valid | input | 1 | Incoming character is available |
| in_ready | output | 1 | Core is waiting for an incoming character |
| halted | output | 1 | Core has stopped |

## Verification
The assertions check the handshake rules on every cycle. A pending outgoing byte must stay valid and unchanged until it is accepted, and a pending input request must stay raised until it is served. The two byte ports must never be active at once. Once the halted flag is set, it must stay set and both ports must stay idle. The program counter reaching its top address must lead to the halted flag. Only the bench scenarios can show that the arithmetic, the immediate widening, the branch decisions, the silent register indices, the per-instruction cycle cost and the write protection of the program store give the right results, because each of these shows up only in the bytes a program sends out or in its cycle count.

// File: rtl/tiny16_pkg.sv
`timescale 1ns/1ps
package tiny16_pkg;

  localparam int INSTR_W = 16;
  localparam int OP_W    = 4;
  localparam int IDX_W   = 4;
  localparam int IMM_W   = 8;
  localparam int CHAR_W  = 8;

  typedef enum logic [OP_W-1:0] {
    OP_NOP  = 4'd0,
    OP_LDI  = 4'd1,
    OP_ADD  = 4'd2,
    OP_SUB  = 4'd3,
    OP_ADDI = 4'd4,
    OP_SUBI = 4'd5,
    OP_JMP  = 4'd6,
    OP_JZ   = 4'd7,
    OP_SYS  = 4'd8,
    OP_HALT = 4'd15
  } opcode_e;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [IDX_W-1:0] rd;
    logic [IDX_W-1:0] ra;
    logic [IDX_W-1:0] rb;
  } instr_t;

  typedef enum logic [2:0] {
    ST_FETCH = 3'd0,
    ST_EXEC  = 3'd1,
    ST_OUT   = 3'd2,
    ST_IN    = 3'd3,
    ST_HALT  = 3'd4
  } state_e;

  localparam logic [IMM_W-1:0] SVC_PUTC = 8'd1;
  localparam logic [IMM_W-1:0] SVC_GETC = 8'd2;

endpackage

// File: rtl/tiny16_rst_sync.sv
`timescale 1ns/1ps
module tiny16_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/tiny16_progmem.sv
`timescale 1ns/1ps
module tiny16_progmem #(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 16,
  parameter int DEPTH  = 255
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);

  localparam logic [ADDR_W:0] DEPTH_L = DEPTH[ADDR_W:0];

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rd_data_q;
  logic              wr_ok;
  logic              rd_ok;

  assign wr_ok = wr_en && ({1'b0, wr_addr} < DEPTH_L);
  assign rd_ok = rd_en && ({1'b0, rd_addr} < DEPTH_L);

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      mem[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_ok) begin
      rd_data_q <= mem[rd_addr];
    end
  end

  assign rd_data = rd_data_q;

endmodule

// File: rtl/tiny16_regfile.sv
`timescale 1ns/1ps
module tiny16_regfile #(
  parameter int DATA_W  = 16,
  parameter int NUM_GPR = 5,
  parameter int IDX_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  idx_a,
  input  logic [IDX_W-1:0]  idx_b,
  input  logic [IDX_W-1:0]  idx_d,
  output logic [DATA_W-1:0] val_a,
  output logic [DATA_W-1:0] val_b,
  output logic [DATA_W-1:0] val_d
);

  logic [DATA_W-1:0] regs [1:NUM_GPR];

  for (genvar g = 1; g <= NUM_GPR; g++) begin : g_reg
    logic              hit;
    logic [DATA_W-1:0] q;

    assign hit = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (hit) begin
        q <= wr_data;
      end
    end

    assign regs[g] = q;
  end

  function automatic logic [DATA_W-1:0] read_port(input logic [IDX_W-1:0] idx);
    logic [DATA_W-1:0] v;
    v = '0;
    for (int i = 1; i <= NUM_GPR; i++) begin
      if (idx == IDX_W'(i)) begin
        v = regs[i];
      end
    end
    return v;
  endfunction

  always_comb begin
    val_a = read_port(idx_a);
    val_b = read_port(idx_b);
    val_d = read_port(idx_d);
  end

endmodule

// File: rtl/tiny16_alu.sv
`timescale 1ns/1ps
module tiny16_alu
  import tiny16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  opcode_e            op,
  input  logic [DATA_W-1:0]  src_a,
  input  logic [DATA_W-1:0]  src_b,
  input  logic [DATA_W-1:0]  src_d,
  input  logic [IMM_W-1:0]   imm,
  output logic [DATA_W-1:0]  result,
  output logic               writes
);

  localparam int PAD_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;

  assign imm_ext = {{PAD_W{1'b0}}, imm};

  always_comb begin
    result = '0;
    writes = 1'b0;
    case (op)
      OP_LDI: begin
        result = imm_ext;
        writes = 1'b1;
      end
      OP_ADD: begin
        result = src_a + src_b;
        writes = 1'b1;
      end
      OP_SUB: begin
        result = src_a - src_b;
        writes = 1'b1;
      end
      OP_ADDI: begin
        result = src_d + imm_ext;
        writes = 1'b1;
      end
      OP_SUBI: begin
        result = src_d - imm_ext;
        writes = 1'b1;
      end
      default: begin
        result = '0;
        writes = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/tiny16_core.sv
`timescale 1ns/1ps
module tiny16_core
  import tiny16_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int PC_W        = 8,
  parameter int NUM_GPR     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prog_we,
  input  logic [PC_W-1:0]    prog_addr,
  input  logic [INSTR_W-1:0] prog_data,
  output logic [CHAR_W-1:0]  out_data,
  output logic               out_valid,
  input  logic               out_ready,
  input  logic [CHAR_W-1:0]  in_data,
  input  logic               in_valid,
  output logic               in_ready,
  output logic               halted
);

  localparam int              PROG_DEPTH = (1 << PC_W) - 1;
  localparam logic [PC_W-1:0] LAST_PC    = '1;
  localparam int              CPAD_W     = DATA_W - CHAR_W;

  logic               core_rst_n;
  state_e             state_q, state_d;
  logic [PC_W-1:0]    pc_q, pc_d, pc_inc, target;
  logic               pc_en;
  logic               fetch_en;
  logic               store_we;
  logic [INSTR_W-1:0] word;
  instr_t             ir;
  opcode_e            op;
  logic [IMM_W-1:0]   imm;
  logic [DATA_W-1:0]  val_a, val_b, val_d;
  logic [DATA_W-1:0]  alu_res;
  logic               alu_writes;
  logic               rf_we;
  logic [DATA_W-1:0]  rf_wdata;

  tiny16_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (core_rst_n)
  );

  assign store_we = prog_we && !rst_n;

  tiny16_progmem #(
    .ADDR_W (PC_W),
    .WORD_W (INSTR_W),
    .DEPTH  (PROG_DEPTH)
  ) u_progmem (
    .clk     (clk),
    .wr_en   (store_we),
    .wr_addr (prog_addr),
    .wr_data (prog_data),
    .rd_en   (fetch_en),
    .rd_addr (pc_q),
    .rd_data (word)
  );

  assign ir     = instr_t'(word);
  assign op     = opcode_e'(ir.op);
  assign imm    = {ir.ra, ir.rb};
  assign target = PC_W'(imm);
  assign pc_inc = pc_q + 1'b1;

  tiny16_regfile #(
    .DATA_W  (DATA_W),
    .NUM_GPR (NUM_GPR),
    .IDX_W   (IDX_W)
  ) u_regfile (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .wr_en   (rf_we),
    .wr_idx  (ir.rd),
    .wr_data (rf_wdata),
    .idx_a   (ir.ra),
    .idx_b   (ir.rb),
    .idx_d   (ir.rd),
    .val_a   (val_a),
    .val_b   (val_b),
    .val_d   (val_d)
  );

  tiny16_alu #(
    .DATA_W (DATA_W)
  ) u_alu (
    .op     (op),
    .src_a  (val_a),
    .src_b  (val_b),
    .src_d  (val_d),
    .imm    (imm),
    .result (alu_res),
    .writes (alu_writes)
  );

  // Next-state and datapath control
  always_comb begin
    state_d  = state_q;
    pc_d     = pc_q;
    pc_en    = 1'b0;
    fetch_en = 1'b0;
    rf_we    = 1'b0;
    rf_wdata = alu_res;
    case (state_q)
      ST_FETCH: begin
        if (pc_q == LAST_PC) begin
          state_d = ST_HALT;
        end else begin
          fetch_en = 1'b1;
          state_d  = ST_EXEC;
        end
      end
      ST_EXEC: begin
        state_d = ST_FETCH;
        pc_d    = pc_inc;
        pc_en   = 1'b1;
        rf_we   = alu_writes;
        case (op)
          OP_JMP: pc_d = target;
          OP_JZ: begin
            if (val_d == '0) begin
              pc_d = target;
            end
          end
          OP_SYS: begin
            if (imm == SVC_PUTC) begin
              state_d = ST_OUT;
              pc_en   = 1'b0;
            end else if (imm == SVC_GETC) begin
              state_d = ST_IN;
              pc_en   = 1'b0;
            end
          end
          OP_HALT: begin
            state_d = ST_HALT;
            pc_en   = 1'b0;
          end
          default: ;
        endcase
      end
      ST_OUT: begin
        if (out_ready) begin
          state_d = ST_FETCH;
          pc_d    = pc_inc;
          pc_en   = 1'b1;
        end
      end
      ST_IN: begin
        if (in_valid) begin
          rf_we    = 1'b1;
          rf_wdata = {{CPAD_W{1'b0}}, in_data};
          state_d  = ST_FETCH;
          pc_d     = pc_inc;
          pc_en    = 1'b1;
        end
      end
      ST_HALT: state_d = ST_HALT;
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      state_q <= ST_FETCH;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      pc_q <= '0;
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end

  assign out_valid = (state_q == ST_OUT);
  assign out_data  = val_d[CHAR_W-1:0];
  assign in_ready  = (state_q == ST_IN);
  assign halted    = (state_q == ST_HALT);

endmodule

// File: rtl/tiny16_core_chk.sv
`timescale 1ns/1ps
module tiny16_core_chk #(
  parameter int PC_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [7:0]      out_data,
  input logic            out_valid,
  input logic            out_ready,
  input logic            in_valid,
  input logic            in_ready,
  input logic            halted,
  input logic [PC_W-1:0] pc
);

  assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_in_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> in_ready);

  assert_ports_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && in_ready));

  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  assert_halt_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!out_valid && !in_ready));

  assert_top_address_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pc == '1) |=> halted);

endmodule

bind tiny16_core tiny16_core_chk #(.PC_W(PC_W)) u_chk (
  .clk       (clk),
  .rst_n     (core_rst_n),
  .out_data  (out_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .halted    (halted),
  .pc        (pc_q)
);

// File: tb/tiny16_core_test.sv
`timescale 1ns/1ps
module tiny16_core_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        prog_we;
  logic [7:0]  prog_addr;
  logic [15:0] prog_data;
  logic [7:0]  out_data;
  logic        out_valid;
  logic        out_ready;
  logic [7:0]  in_data;
  logic        in_valid;
  logic        in_ready;
  logic        halted;

  always #5 clk = ~clk;

  tiny16_core uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_we   (prog_we),
    .prog_addr (prog_addr),
    .prog_data (prog_data),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .halted    (halted)
  );

  int          checks = 0;
  int          errors = 0;
  logic [15:0] pbuf [0:254];
  logic [7:0]  obuf [0:63];
  int          ocnt;
  logic [7:0]  ibuf [0:7];
  int          iidx;
  logic        in_en;

  assign in_valid = in_en;
  assign in_data  = ibuf[iidx[2:0]];

  // Stimulus table: {opcode, a, b, expected low byte}
  localparam logic [27:0] VECS [0:7] = '{
    {4'd2, 8'd10,  8'd20,  8'd30},
    {4'd2, 8'd200, 8'd100, 8'd44},
    {4'd3, 8'd50,  8'd8,   8'd42},
    {4'd3, 8'd5,   8'd7,   8'd254},
    {4'd4, 8'd100, 8'd27,  8'd127},
    {4'd4, 8'd255, 8'd1,   8'd0},
    {4'd5, 8'd65,  8'd1,   8'd64},
    {4'd5, 8'd0,   8'd1,   8'd255}
  };

  always @(posedge clk) begin
    if (!rst_n) begin
      ocnt <= 0;
      iidx <= 0;
    end else begin
      if (out_valid && out_ready && ocnt < 64) begin
        obuf[ocnt] <= out_data;
        ocnt <= ocnt + 1;
      end
      if (in_valid && in_ready) begin
        iidx <= iidx + 1;
      end
    end
  end

  function automatic logic [15:0] enc(input logic [3:0] op, input logic [3:0] d,
                                      input logic [3:0] a, input logic [3:0] b);
    return {op, d, a, b};
  endfunction

  function automatic logic [15:0] enci(input logic [3:0] op, input logic [3:0] d,
                                       input logic [7:0] k);
    return {op, d, k};
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int a = 0; a < 255; a++) pbuf[a] = 16'h0000;
  endtask

  task automatic load_prog();
    @(negedge clk);
    rst_n = 1'b0;
    for (int a = 0; a < 255; a++) begin
      prog_we   = 1'b1;
      prog_addr = 8'(a);
      prog_data = pbuf[a];
      @(negedge clk);
    end
    prog_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic start_and_wait(output int cyc);
    rst_n = 1'b1;
    cyc = 0;
    while (!halted && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    check("R8", "run reaches halted", int'(halted), 1);
  endtask

  task automatic run_prog(output int cyc);
    load_prog();
    start_and_wait(cyc);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cyc, cyc0, cyc1;
    logic [3:0] vop;
    logic [7:0] va, vb, vexp;

    rst_n     = 1'b0;
    prog_we   = 1'b0;
    prog_addr = '0;
    prog_data = '0;
    out_ready = 1'b1;
    in_en     = 1'b0;
    for (int i = 0; i < 8; i++) ibuf[i] = 8'h00;

    // R11: outputs while held in reset
    repeat (3) @(negedge clk);
    check("R11", "halted in reset", int'(halted), 0);
    check("R11", "out_valid in reset", int'(out_valid), 0);
    check("R11", "in_ready in reset", int'(in_ready), 0);

    // R1 R2 R3: table of arithmetic vectors
    for (int v = 0; v < 8; v++) begin
      {vop, va, vb, vexp} = VECS[v];
      clear_prog();
      pbuf[0] = enci(4'd1, 4'd1, va);
      pbuf[1] = enci(4'd1, 4'd2, vb);
      pbuf[2] = enci(4'd1, 4'd3, va);
      if (vop < 4'd4) pbuf[3] = enc(vop, 4'd3, 4'd1, 4'd2);
      else            pbuf[3] = enci(vop, 4'd3, vb);
      pbuf[4] = enci(4'd8, 4'd3, 8'd1);
      pbuf[5] = enci(4'd15, 4'd0, 8'd0);
      run_prog(cyc);
      check(vop < 4'd4 ? "R2" : "R3", "vector output count", ocnt, 1);
      check(vop < 4'd4 ? "R2" : "R3", "vector result", int'(obuf[0]), int'(vexp));
    end

    // R11: a new reset clears registers set by the previous run
    clear_prog();
    pbuf[0] = enci(4'd8, 4'd3, 8'd1);
    pbuf[1] = enci(4'd8, 4'd1, 8'd1);
    pbuf[2] = enci(4'd15, 4'd0, 8'd0);
    run_prog(cyc);
    check("R11", "register 3 after reset", int'(obuf[0]), 0);
    check("R11", "register 1 after reset", int'(obuf[1]), 0);

    // R4: counted loop printing A..Z
    clear_prog();
    pbuf[0] = enci(4'd1, 4'd1, 8'd26);
    pbuf[1] = enci(4'd1, 4'd2, 8'd65);
    pbuf[2] = enci(4'd7, 4'd1, 8'd7);
    pbuf[3] = enci(4'd8, 4'd2, 8'd1);
    pbuf[4] = enci(4'd4, 4'd2, 8'd1);
    pbuf[5] = enci(4'd5, 4'd1, 8'd1);
    pbuf[6] = enci(4'd6, 4'd0, 8'd2);
    pbuf[7] = enci(4'd15, 4'd0, 8'd0);
    run_prog(cyc);
    check("R4", "loop output count", ocnt, 26);
    for (int i = 0; i < 26; i++) check("R4", "loop character", int'(obuf[i]), 65 + i);

    // R2 R4: full 16-bit wrap observed through zero tests
    clear_prog();
    pbuf[0]  = enci(4'd1, 4'd1, 8'd0);
    pbuf[1]  = enci(4'd5, 4'd1, 8'd1);
    pbuf[2]  = enci(4'd1, 4'd2, 8'd255);
    pbuf[3]  = enc(4'd3, 4'd3, 4'd1, 4'd2);
    pbuf[4]  = enci(4'd7, 4'd3, 8'd10);
    pbuf[5]  = enc(4'd2, 4'd3, 4'd3, 4'd2);
    pbuf[6]  = enci(4'd4, 4'd3, 8'd1);
    pbuf[7]  = enci(4'd7, 4'd3, 8'd12);
    pbuf[8]  = enci(4'd1, 4'd5, 8'd78);
    pbuf[9]  = enci(4'd6, 4'd0, 8'd13);
    pbuf[10] = enci(4'd1, 4'd5, 8'd110);
    pbuf[11] = enci(4'd6, 4'd0, 8'd13);
    pbuf[12] = enci(4'd1, 4'd5, 8'd89);
    pbuf[13] = enci(4'd8, 4'd5, 8'd1);
    pbuf[14] = enci(4'd15, 4'd0, 8'd0);
    run_prog(cyc);
    check("R2", "wrap path marker", int'(obuf[0]), 89);

    // R5: silent register indices
    clear_prog();
    pbuf[0] = enci(4'd1, 4'd0, 8'd7);
    pbuf[1] = enci(4'd1, 4'd6, 8'd9);
    pbuf[2] = enci(4'd1, 4'd5, 8'd3);
    pbuf[3] = enc(4'd2, 4'd1, 4'd0, 4'd5);
    pbuf[4] = enci(4'd8, 4'd0, 8'd1);
    pbuf[5] = enci(4'd8, 4'd6, 8'd1);
    pbuf[6] = enci(4'd8, 4'd15, 8'd1);
    pbuf[7] = enci(4'd8, 4'd1, 8'd1);
    pbuf[8] = enci(4'd15, 4'd0, 8'd0);
    run_prog(cyc);
    check("R5", "output count", ocnt, 4);
    check("R5", "register 0 reads zero", int'(obuf[0]), 0);
    check("R5", "register 6 reads zero", int'(obuf[1]), 0);
    check("R5", "register 15 reads zero", int'(obuf[2]), 0);
    check("R5", "register 0 as source", int'(obuf[3]), 3);

    // R10: cycle cost and undefined opcodes
    clear_prog();
    pbuf[0] = enci(4'd15, 4'd0, 8'd0);
    run_prog(cyc0);
    clear_prog();
    pbuf[4] = enci(4'd15, 4'd0, 8'd0);
    run_prog(cyc1);
    check("R10", "four no-ops cost", cyc1 - cyc0, 8);
    clear_prog();
    pbuf[0] = enci(4'd1, 4'd1, 8'd5);
    pbuf[1] = 16'h9155;
    pbuf[2] = 16'hE1FF;
    pbuf[3] = enci(4'd8, 4'd1, 8'd7);
    pbuf[4] = enci(4'd8, 4'd1, 8'd1);
    pbuf[5] = enci(4'd15, 4'd0, 8'd0);
    run_prog(cyc1);
    check("R10", "undefined opcodes leave register", int'(obuf[0]), 5);
    check("R10", "undefined opcodes output count", ocnt, 1);
    check("R10", "cycles with one output", cyc1 - cyc0, 11);

    // R8: halt stops execution
    clear_prog();
    pbuf[0] = enci(4'd1, 4'd1, 8'd120);
    pbuf[1] = enci(4'd15, 4'd0, 8'd0);
    pbuf[2] = enci(4'd8, 4'd1, 8'd1);
    run_prog(cyc);
    repeat (20) @(negedge clk);
    check("R8", "nothing after halt", ocnt, 0);
    check("R8", "halted stays set", int'(halted), 1);

    // R8: running off the top address
    clear_prog();
    pbuf[0] = enci(4'd6, 4'd0, 8'd250);
    run_prog(cyc1);
    check("R8", "top address halt timing", cyc1 - cyc0, 11);
    check("R8", "top address no output", ocnt, 0);

    // R6: output back-pressure
    clear_prog();
    pbuf[0] = enci(4'd1, 4'd1, 8'd81);
    pbuf[1] = enci(4'd8, 4'd1, 8'd1);
    pbuf[2] = enci(4'd15, 4'd0, 8'd0);
    load_prog();
    out_ready = 1'b0;
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
    check("R6", "out_valid while stalled", int'(out_valid), 1);
    check("R6", "out_data while stalled", int'(out_data), 81);
    check("R6", "not halted while stalled", int'(halted), 0);
    out_ready = 1'b1;
    start_and_wait(cyc);
    check("R6", "stalled byte delivered once", ocnt, 1);
    check("R6", "stalled byte value", int'(obuf[0]), 81);

    // R7: character input with zero extension
    ibuf[0] = 8'd65;
    ibuf[1] = 8'd122;
    clear_prog();
    pbuf[0]  = enci(4'd1, 4'd4, 8'd255);
    pbuf[1]  = enc(4'd2, 4'd4, 4'd4, 4'd4);
    pbuf[2]  = enci(4'd8, 4'd4, 8'd2);
    pbuf[3]  = enci(4'd5, 4'd4, 8'd65);
    pbuf[4]  = enci(4'd7, 4'd4, 8'd7);
    pbuf[5]  = enci(4'd1, 4'd5, 8'd78);
    pbuf[6]  = enci(4'd6, 4'd0, 8'd8);
    pbuf[7]  = enci(4'd1, 4'd5, 8'd89);
    pbuf[8]  = enci(4'd8, 4'd5, 8'd1);
    pbuf[9]  = enci(4'd8, 4'd2, 8'd2);
    pbuf[10] = enci(4'd8, 4'd2, 8'd1);
    pbuf[11] = enci(4'd15, 4'd0, 8'd0);
    load_prog();
    in_en = 1'b0;
    rst_n = 1'b1;
    repeat (15) @(negedge clk);
    check("R7", "in_ready while waiting", int'(in_ready), 1);
    check("R7", "out_valid while waiting", int'(out_valid), 0);
    in_en = 1'b1;
    start_and_wait(cyc);
    in_en = 1'b0;
    check("R7", "zero-extended input", int'(obuf[0]), 89);
    check("R7", "second input echoed", int'(obuf[1]), 122);

    // R9: store is write-protected outside reset
    clear_prog();
    pbuf[0] = enci(4'd1, 4'd1, 8'd97);
    pbuf[1] = enci(4'd8, 4'd1, 8'd1);
    pbuf[2] = enci(4'd15, 4'd0, 8'd0);
    run_prog(cyc);
    check("R9", "first run output", int'(obuf[0]), 97);
    @(negedge clk);
    prog_we   = 1'b1;
    prog_addr = 8'd0;
    prog_data = enci(4'd1, 4'd1, 8'd98);
    @(negedge clk);
    prog_we = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    start_and_wait(cyc);
    check("R9", "rerun output unchanged", int'(obuf[0]), 97);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule